// File: doc/BRIEF.md
# Serial Frame Decoder with Split-Word Reassembly

This block takes a received serial stream, one bit per cycle in which its bit-enable input is high, and finds the 24-bit frame grid in it. Every frame opens with a 4-bit coding field. The 2nd and 3rd bits of that field always differ, and this guaranteed transition is the only thing the aligner looks for. A 20-bit payload follows the coding field. The aligner tests one candidate boundary per frame. When the test fails, it moves the candidate one bit later. It declares lock only after several hits in a row at frame spacing, and it gives lock up again after repeated misses.

Once locked, each good frame is classified as one of four kinds: padding, control, low half of a data word, or high half of a data word. The payload is complemented when the frame's invert bit is set. A low half and the high half that follows it are joined into one 40-bit word, which is published with a single-cycle valid strobe at the word rate. Control frames deliver their 20-bit payload with a separate strobe. Padding frames are reported with a pulse and carry no data. A pairing fault produces an error pulse. Clock recovery lies outside the block and appears here only as the bit-enable input.

Top module: `fdec_top`

## Requirements
- R1: A frame is 24 bits, first received bit first. The bits are: coding bit c3, c2, c1, invert bit, then the payload from bit 19 down to bit 0. A high word half occupies output bits 39:20 and a low half occupies bits 19:0.
- R2: Lock (`lock_o`) rises in the cycle after the bit that completes the 4th consecutive frame with c2 != c1 at 24-bit spacing. The frame that completes lock is not decoded; decoding starts with the next frame.
- R3: While unlocked, a frame window without the transition resets the hit count and moves the next candidate boundary one bit later, so that the very next bit closes a window.
- R4: While locked, one bad frame followed by a good one keeps lock. The 2nd consecutive bad frame drops lock. A bad frame produces no strobe and leaves a held low half untouched.
- R5: The frame kind is {c3,c2}: 00 padding, 01 control, 10 low half, 11 high half. c1 is always the complement of c2.
- R6: When the invert bit is 1, the payload used for every kind is the bitwise complement of the received payload.
- R7: A high half that follows a held low half sets `word_o` = {high, low} and pulses `word_vld_o` for one cycle in the same cycle.
- R8: A control frame updates `ctrl_o` and pulses `ctrl_vld_o` for one cycle. A held low half is kept across it.
- R9: A padding frame pulses `pad_o` and gives no data strobe. Padding frames count as hits toward lock and keep a held low half.
- R10: A high half with no held low half, or a second low half in a row, pulses `err_o` and produces no word. In the second case the newer low half replaces the held one.
- R11: At most one of the four strobes is high in any cycle, and a strobe only follows a cycle with the bit-enable high. `word_o` and `ctrl_o` hold their values until their own next strobe.
- R12: Under reset all outputs are zero.
- R13: Losing lock discards a held low half, so a high half received after lock is regained raises `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Recovered bit strobe; `ser_in` is taken when high |
| ser_in | input | 1 | Serial line data |
| lock_o | output | 1 | Frame alignment locked |
| word_o | output | 40 | Reassembled data word |
| word_vld_o | output | 1 | One-cycle strobe for a new word |
| ctrl_o | output | 20 | Last control payload |
| ctrl_vld_o | output | 1 | One-cycle strobe for a control frame |
| pad_o | output | 1 | One-cycle pulse for a padding frame |
| err_o | output | 1 | One-cycle pulse for a half-pairing fault |

## Verification
Two functions can fall on the same frame-completing edge. The first pair is lock declaration and frame decoding: the 4th hitting frame has to raise lock without producing a strobe. The second pair is lock loss and half-word pairing: a low half held before the drop must not combine with a high half received after re-acquisition. Both cases are provoked by directed sequences of zero bits and padding frames that place the grid at a chosen bit offset. They are judged at the end of each frame by comparing the strobe counts, `lock_o` and the held outputs with a bench model. Randomised frame kinds, invert bits, payloads, bit-enable gaps and single bad frames then cover the ordinary decoding paths.

// File: rtl/fdec_pkg.sv
package fdec_pkg;
  // Frame kind carried in the first two coding bits.
  typedef enum logic [1:0] {
    KIND_PAD  = 2'b00,
    KIND_CTRL = 2'b01,
    KIND_LO   = 2'b10,
    KIND_HI   = 2'b11
  } kind_e;

  localparam int CODE_W = 4;
endpackage

// File: rtl/fdec_aligner.sv
module fdec_aligner #(
  parameter int HALF_W      = 20,
  parameter int LOCK_HITS   = 4,
  parameter int DROP_MISSES = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             bit_en,
  input  logic                             ser_in,
  output logic                             frm_stb,
  output logic [HALF_W+fdec_pkg::CODE_W-1:0] frm_bits,
  output logic                             locked
);
  localparam int FRAME_W = HALF_W + fdec_pkg::CODE_W;
  localparam int POS_W   = $clog2(FRAME_W);
  localparam int CNT_MAX = (LOCK_HITS > DROP_MISSES) ? LOCK_HITS : DROP_MISSES;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [FRAME_W-1:0] sr_q, sr_d, sr_shift;
  logic [POS_W-1:0]   pos_q, pos_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               lock_q, lock_d;
  logic               boundary, hit;

  assign sr_shift = {sr_q[FRAME_W-2:0], ser_in};
  assign boundary = bit_en && (pos_q == POS_W'(FRAME_W - 1));
  // transition between the 2nd and 3rd coding bits
  assign hit      = sr_shift[FRAME_W-2] != sr_shift[FRAME_W-3];

  always_comb begin
    sr_d    = sr_q;
    pos_d   = pos_q;
    cnt_d   = cnt_q;
    lock_d  = lock_q;
    frm_stb = 1'b0;
    if (bit_en) begin
      sr_d  = sr_shift;
      pos_d = (pos_q == POS_W'(FRAME_W - 1)) ? '0 : pos_q + POS_W'(1);
    end
    if (boundary) begin
      if (!lock_q) begin
        if (hit) begin
          if (cnt_q == CNT_W'(LOCK_HITS - 1)) begin
            lock_d = 1'b1;
            cnt_d  = '0;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end else begin
          cnt_d = '0;
          pos_d = pos_q;          // slip: next bit closes a window
        end
      end else begin
        if (hit) begin
          cnt_d   = '0;
          frm_stb = 1'b1;
        end else if (cnt_q == CNT_W'(DROP_MISSES - 1)) begin
          lock_d = 1'b0;
          cnt_d  = '0;
          pos_d  = pos_q;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      pos_q  <= '0;
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else if (bit_en) begin
      sr_q   <= sr_d;
      pos_q  <= pos_d;
      cnt_q  <= cnt_d;
      lock_q <= lock_d;
    end
  end

  assign frm_bits = sr_shift;
  assign locked   = lock_q;
endmodule

// File: rtl/fdec_fields.sv
module fdec_fields
  import fdec_pkg::*;
#(
  parameter int HALF_W = 20
) (
  input  logic [HALF_W+CODE_W-1:0] frame,
  output kind_e                    kind,
  output logic [HALF_W-1:0]        payload
);
  localparam int FRAME_W = HALF_W + CODE_W;

  logic inv;

  assign kind    = kind_e'(frame[FRAME_W-1 -: 2]);
  assign inv     = frame[FRAME_W-CODE_W];
  assign payload = inv ? ~frame[HALF_W-1:0] : frame[HALF_W-1:0];
endmodule

// File: rtl/fdec_assembler.sv
module fdec_assembler
  import fdec_pkg::*;
#(
  parameter int HALF_W = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                locked,
  input  logic                frm_stb,
  input  kind_e               kind,
  input  logic [HALF_W-1:0]   payload,
  output logic [2*HALF_W-1:0] word_o,
  output logic                word_vld_o,
  output logic [HALF_W-1:0]   ctrl_o,
  output logic                ctrl_vld_o,
  output logic                pad_o,
  output logic                err_o
);
  localparam int WORD_W = 2 * HALF_W;

  logic [HALF_W-1:0] low_q, low_d;
  logic              have_q, have_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic [HALF_W-1:0] ctrl_q, ctrl_d;
  logic              wv_d, cv_d, pad_d, err_d;
  logic              wv_q, cv_q, pad_q, err_q;

  always_comb begin
    low_d  = low_q;
    have_d = have_q && locked;
    word_d = word_q;
    ctrl_d = ctrl_q;
    wv_d   = 1'b0;
    cv_d   = 1'b0;
    pad_d  = 1'b0;
    err_d  = 1'b0;
    if (frm_stb) begin
      unique case (kind)
        KIND_PAD:  pad_d = 1'b1;
        KIND_CTRL: begin
          cv_d   = 1'b1;
          ctrl_d = payload;
        end
        KIND_LO: begin
          err_d  = have_q;
          have_d = 1'b1;
          low_d  = payload;
        end
        KIND_HI: begin
          if (have_q) begin
            wv_d   = 1'b1;
            word_d = {payload, low_q};
            have_d = 1'b0;
          end else begin
            err_d = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q  <= '0;
      have_q <= 1'b0;
      word_q <= '0;
      ctrl_q <= '0;
      wv_q   <= 1'b0;
      cv_q   <= 1'b0;
      pad_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      have_q <= have_d;
      wv_q   <= wv_d;
      cv_q   <= cv_d;
      pad_q  <= pad_d;
      err_q  <= err_d;
      if (frm_stb) begin
        low_q  <= low_d;
        word_q <= word_d;
        ctrl_q <= ctrl_d;
      end
    end
  end

  assign word_o     = word_q;
  assign word_vld_o = wv_q;
  assign ctrl_o     = ctrl_q;
  assign ctrl_vld_o = cv_q;
  assign pad_o      = pad_q;
  assign err_o      = err_q;
endmodule

// File: rtl/fdec_top.sv
module fdec_top
  import fdec_pkg::*;
#(
  parameter int HALF_W      = 20,
  parameter int LOCK_HITS   = 4,
  parameter int DROP_MISSES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_en,
  input  logic                ser_in,
  output logic                lock_o,
  output logic [2*HALF_W-1:0] word_o,
  output logic                word_vld_o,
  output logic [HALF_W-1:0]   ctrl_o,
  output logic                ctrl_vld_o,
  output logic                pad_o,
  output logic                err_o
);
  localparam int FRAME_W = HALF_W + CODE_W;

  logic               frm_stb;
  logic [FRAME_W-1:0] frm_bits;
  logic               locked;
  kind_e              kind;
  logic [HALF_W-1:0]  payload;

  fdec_aligner #(
    .HALF_W(HALF_W), .LOCK_HITS(LOCK_HITS), .DROP_MISSES(DROP_MISSES)
  ) u_align (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .ser_in(ser_in),
    .frm_stb(frm_stb), .frm_bits(frm_bits), .locked(locked)
  );

  fdec_fields #(.HALF_W(HALF_W)) u_fields (
    .frame(frm_bits), .kind(kind), .payload(payload)
  );

  fdec_assembler #(.HALF_W(HALF_W)) u_asm (
    .clk(clk), .rst_n(rst_n), .locked(locked), .frm_stb(frm_stb),
    .kind(kind), .payload(payload),
    .word_o(word_o), .word_vld_o(word_vld_o),
    .ctrl_o(ctrl_o), .ctrl_vld_o(ctrl_vld_o),
    .pad_o(pad_o), .err_o(err_o)
  );

  assign lock_o = locked;
endmodule

// File: rtl/fdec_chk.sv
module fdec_chk #(
  parameter int HALF_W = 20
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bit_en,
  input logic                lock_o,
  input logic [2*HALF_W-1:0] word_o,
  input logic                word_vld_o,
  input logic [HALF_W-1:0]   ctrl_o,
  input logic                ctrl_vld_o,
  input logic                pad_o,
  input logic                err_o
);
  logic evt;
  assign evt = word_vld_o || ctrl_vld_o || pad_o || err_o;

  assert_one_event_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({word_vld_o, ctrl_vld_o, pad_o, err_o}));

  assert_event_after_bit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> $past(bit_en));

  assert_word_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !word_vld_o |-> $stable(word_o));

  assert_ctrl_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_vld_o |-> $stable(ctrl_o));

  assert_event_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> (lock_o && $past(lock_o)));

  assert_drop_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_o) |-> !evt);

  assert_lock_moves_on_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(lock_o) || $fell(lock_o)) |-> $past(bit_en));
endmodule

bind fdec_top fdec_chk #(.HALF_W(HALF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .lock_o(lock_o),
  .word_o(word_o), .word_vld_o(word_vld_o), .ctrl_o(ctrl_o),
  .ctrl_vld_o(ctrl_vld_o), .pad_o(pad_o), .err_o(err_o)
);

// File: tb/sim_fdec_top.sv
module sim_fdec_top;
  localparam int HW = 20;
  localparam int FW = HW + 4;
  localparam int WW = 2 * HW;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n, bit_en, ser_in;
  logic          lock_o, word_vld_o, ctrl_vld_o, pad_o, err_o;
  logic [WW-1:0] word_o;
  logic [HW-1:0] ctrl_o;

  fdec_top u0 (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .ser_in(ser_in),
    .lock_o(lock_o), .word_o(word_o), .word_vld_o(word_vld_o),
    .ctrl_o(ctrl_o), .ctrl_vld_o(ctrl_vld_o), .pad_o(pad_o), .err_o(err_o)
  );

  int checks = 0;
  int errors = 0;
  int a_word, a_ctrl, a_pad, a_err;
  logic          m_have;
  logic [HW-1:0] m_low;
  logic [WW-1:0] m_word;
  logic [HW-1:0] m_ctrl;

  // R1 R5: frame = {kind, ~kind[0], inv, payload (inverted when inv)}
  function automatic logic [FW-1:0] mk(input logic [1:0] k, input logic inv,
                                       input logic [HW-1:0] p);
    return {k[1], k[0], ~k[0], inv, (inv ? ~p : p)};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    ser_in = b;
    bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
    if (word_vld_o) a_word++;
    if (ctrl_vld_o) a_ctrl++;
    if (pad_o)      a_pad++;
    if (err_o)      a_err++;
    repeat ($urandom_range(0, 2)) @(negedge clk);
  endtask

  task automatic clear_acc();
    a_word = 0; a_ctrl = 0; a_pad = 0; a_err = 0;
  endtask

  task automatic send_frame(input logic [FW-1:0] f);
    clear_acc();
    for (int i = FW - 1; i >= 0; i--) send_bit(f[i]);
  endtask

  task automatic expect_out(input string req, input int ew, input int ec,
                            input int ep, input int ee, input logic el);
    chk({req, " word strobe"}, 64'(a_word), 64'(ew));
    chk({req, " ctrl strobe"}, 64'(a_ctrl), 64'(ec));
    chk({req, " pad pulse"},   64'(a_pad),  64'(ep));
    chk({req, " err pulse"},   64'(a_err),  64'(ee));
    chk({req, " lock"},        64'(lock_o), 64'(el));
    chk({req, " word value"},  64'(word_o), 64'(m_word));
    chk({req, " ctrl value"},  64'(ctrl_o), 64'(m_ctrl));
  endtask

  // Model of one good frame while locked (R5..R10)
  task automatic do_frame(input string req, input logic [1:0] k, input logic inv,
                          input logic [HW-1:0] p);
    int ew, ec, ep, ee;
    ew = 0; ec = 0; ep = 0; ee = 0;
    send_frame(mk(k, inv, p));
    case (k)
      2'b00: ep = 1;
      2'b01: begin ec = 1; m_ctrl = p; end
      2'b10: begin
        if (m_have) ee = 1;
        m_have = 1'b1;
        m_low  = p;
      end
      default: begin
        if (m_have) begin
          ew = 1;
          m_word = {p, m_low};
          m_have = 1'b0;
        end else begin
          ee = 1;
        end
      end
    endcase
    expect_out(req, ew, ec, ep, ee, 1'b1);
  endtask

  // A frame of zeros never shows the transition (R4)
  task automatic bad_frame(input string req, input logic exp_lock);
    send_frame('0);
    expect_out(req, 0, 0, 0, 0, exp_lock);
    if (!exp_lock) m_have = 1'b0;
  endtask

  // k zero bits then padding frames: the grid is found at the first
  // padding frame, lock after the 4th (R2 R3 R9)
  task automatic acquire(input int k);
    clear_acc();
    for (int i = 0; i < k; i++) send_bit(1'b0);
    for (int n = 1; n <= 4; n++) begin
      send_frame(mk(2'b00, 1'($urandom_range(0, 1)), HW'($urandom)));
      if (n == 3) expect_out("R3 hunt before 4th hit", 0, 0, 0, 0, 1'b0);
      if (n == 4) expect_out("R2 lock on 4th hit, frame not decoded", 0, 0, 0, 0, 1'b1);
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int miss_prev;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; bit_en = 1'b0; ser_in = 1'b0;
    m_have = 1'b0; m_low = '0; m_word = '0; m_ctrl = '0;
    clear_acc();
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 lock", 64'(lock_o), 64'd0);
    chk("R12 word", 64'(word_o), 64'd0);
    chk("R12 ctrl", 64'(ctrl_o), 64'd0);
    chk("R12 strobes", 64'({word_vld_o, ctrl_vld_o, pad_o, err_o}), 64'd0);
    rst_n = 1'b1;

    acquire($urandom_range(1, 20));

    // R6 R7: inverted low half, plain high half
    do_frame("R6 low inverted", 2'b10, 1'b1, 20'h0F0F3);
    do_frame("R7 word join", 2'b11, 1'b0, 20'hABCDE);
    // R8 R9: control and padding between halves keep the low half
    do_frame("R7 low", 2'b10, 1'b0, 20'h12345);
    do_frame("R8 ctrl between halves", 2'b01, 1'b1, 20'h5A5A5);
    do_frame("R9 pad between halves", 2'b00, 1'b0, 20'hFFFFF);
    do_frame("R8 word after ctrl", 2'b11, 1'b1, 20'h00001);
    // R10 pairing faults
    do_frame("R10 high without low", 2'b11, 1'b0, 20'h77777);
    do_frame("R10 first low", 2'b10, 1'b0, 20'h11111);
    do_frame("R10 second low", 2'b10, 1'b0, 20'h22222);
    do_frame("R10 word uses newer low", 2'b11, 1'b0, 20'h33333);
    // R4 single miss keeps lock and the held half
    do_frame("R4 low", 2'b10, 1'b0, 20'h44444);
    bad_frame("R4 single miss", 1'b1);
    do_frame("R4 word after miss", 2'b11, 1'b0, 20'h55555);
    // R4 R13 double miss drops lock and discards the half
    do_frame("R13 low", 2'b10, 1'b1, 20'h66666);
    bad_frame("R4 first miss", 1'b1);
    bad_frame("R4 second miss drops lock", 1'b0);
    acquire($urandom_range(0, 20));
    do_frame("R13 high after relock", 2'b11, 1'b0, 20'h88888);

    // Random traffic with occasional single misses (R5..R11)
    miss_prev = 0;
    for (int i = 0; i < 350; i++) begin
      if (miss_prev == 0 && $urandom_range(0, 15) == 0) begin
        bad_frame("R4 random single miss", 1'b1);
        miss_prev = 1;
      end else begin
        int r;
        logic [1:0] k;
        r = $urandom_range(0, 9);
        k = (r < 4) ? 2'b10 : (r < 8) ? 2'b11 : (r == 8) ? 2'b01 : 2'b00;
        do_frame("R11 random frame", k, 1'($urandom_range(0, 1)), HW'($urandom));
        miss_prev = 0;
      end
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule